// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block keeps an EDO DRAM's contents alive. A free-running interval timer marks each point at which one CAS-before-RAS refresh is due, and a small saturating backlog counter remembers refreshes that could not be issued yet. Whenever refresh work is pending, the block raises a request to the access sequencer and waits for a grant. The sequencer gives the grant only once its open page is closed and RAS# is high. The block then takes over the strobes, lowers CAS# first, then RAS#, keeps WE# high throughout, and hands the bus back after the precharge time. No row address is driven, because the device's internal row counter picks the row.

A level request places the device in its low-power retention mode. The block starts a CBR cycle and keeps RAS# and CAS# low for as long as the request stands, and for no less than a minimum hold time. When the request drops, it drives both strobes high for a fixed exit precharge time. If the controller was configured for a non-distributed refresh scheme, the block then runs a back-to-back catch-up burst of CBR cycles. Only after that does it release the bus. The interval period defaults to 64 ms spread over 4,096 cycles at the configured clock rate.

Top module: `refresh_sched`

## Requirements
- R1: After reset, ras_n, cas_n and we_n are 1, ref_req is 0, busy is 0 and sr_active is 0.
- R2: With no grant given, ref_req goes to 1 exactly INTERVAL clock edges after reset release and is 0 one edge earlier, where INTERVAL = CLK_MHZ * REF_NS / 1000.
- R3: Each refresh cycle lowers cas_n for CSR_CYC cycles while ras_n is still 1, then holds both low for RAS_CYC cycles, then holds both high (busy still 1) for RP_CYC cycles. ras_n never falls while cas_n is high.
- R4: While ref_req is 1 and ref_gnt is 0, the strobes stay high and busy stays 0. A grant sampled at a clock edge with ref_req at 1 starts the cycle at that edge, and ref_req is 1 only while busy is 0.
- R5: Missed interval ticks accumulate up to MAX_BACKLOG, and further ticks are dropped. With the grant held, exactly that many refresh cycles are issued before ref_req returns to 0.
- R6: With sr_req at 1, a grant starts a CBR entry. After the RAS_CYC strobe phase, sr_active is 1 and ras_n and cas_n stay low while sr_req stays 1.
- R7: In self-refresh, ras_n stays low for at least RASS_CYC cycles even if sr_req drops right after entry.
- R8: When sr_req drops (once the minimum hold has elapsed), sr_active clears at the next edge, and ras_n and cas_n stay high with busy at 1 for exactly RPS_CYC cycles.
- R9: After the exit precharge, if burst_sched is 1, exactly BURST_ROWS refresh cycles run with no grant. If it is 0, no refresh follows and the interval timer restarts from a full period.
- R10: we_n is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant from access sequencer; valid only with page closed |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| burst_sched | input | 1 | 1 = controller uses non-distributed refresh; catch-up burst on exit |
| ref_req | output | 1 | Refresh or self-refresh work waiting for the bus |
| busy | output | 1 | Block owns the DRAM strobes |
| sr_active | output | 1 | Device held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
Several stimulus patterns are applied. First, an ungranted wait isolates the interval period to the exact edge. Next, a delayed single grant shows that nothing moves without a grant and reveals the exact CBR strobe sequence. A long ungranted stretch followed by a held grant separates correct saturation from an unbounded or off-by-one backlog. Self-refresh is run three ways: a long hold with distributed refresh, an early release that exposes the minimum hold, and an exit with the burst option. Together these show the exit precharge length, the presence or absence of the catch-up cycles, and whether the burst count is exact.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CAS  = 3'd1,
    ST_RAS  = 3'd2,
    ST_PRE  = 3'd3,
    ST_SRH  = 3'd4,
    ST_SRX  = 3'd5
  } rs_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = 1'b0;
    if (hold) begin
      cnt_d = RELOAD;
    end else if (cnt_q == '0) begin
      cnt_d = RELOAD;
      tick  = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
  parameter int MAX_BACKLOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  input  logic clear,
  output logic pending
);
  localparam int BW = $clog2(MAX_BACKLOG + 1);
  localparam logic [BW-1:0] FULL = BW'(MAX_BACKLOG);

  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else begin
      unique case ({tick, take})
        2'b10:   cnt_d = (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pending = (cnt_q != '0);
endmodule

// File: rtl/refsched_fsm.sv
module refsched_fsm
  import refsched_pkg::*;
#(
  parameter int CSR_CYC    = 1,
  parameter int RAS_CYC    = 5,
  parameter int RP_CYC     = 3,
  parameter int RASS_CYC   = 10000,
  parameter int RPS_CYC    = 11,
  parameter int BURST_ROWS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic gnt,
  input  logic sr_req,
  input  logic burst_sched,
  output logic take,
  output logic clear,
  output logic hold,
  output logic ref_req,
  output logic busy,
  output logic sr_active,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXD = max_of(max_of(max_of(CSR_CYC, RAS_CYC), max_of(RP_CYC, RPS_CYC)), RASS_CYC);
  localparam int CW   = $clog2(MAXD + 1);
  localparam int NW   = $clog2(BURST_ROWS + 1);
  localparam logic [CW-1:0] L_CSR  = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] L_RAS  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] L_RP   = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] L_RASS = CW'(RASS_CYC - 1);
  localparam logic [CW-1:0] L_RPS  = CW'(RPS_CYC - 1);
  localparam logic [NW-1:0] L_BURST = NW'(BURST_ROWS - 1);

  rs_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] left_q, left_d;
  logic sr_q, sr_d, bon_q, bon_d;
  logic done;

  assign done = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = done ? cnt_q : cnt_q - 1'b1;
    left_d = left_q;
    sr_d   = sr_q;
    bon_d  = bon_q;
    take   = 1'b0;
    clear  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (gnt && sr_req) begin
          st_d = ST_CAS; cnt_d = L_CSR; sr_d = 1'b1; clear = 1'b1;
        end else if (gnt && pending) begin
          st_d = ST_CAS; cnt_d = L_CSR; take = 1'b1;
        end
      end
      ST_CAS: if (done) begin st_d = ST_RAS; cnt_d = L_RAS; end
      ST_RAS: if (done) begin
        if (sr_q) begin st_d = ST_SRH; cnt_d = L_RASS; end
        else      begin st_d = ST_PRE; cnt_d = L_RP;   end
      end
      ST_PRE: if (done) begin
        if (left_q != '0) begin
          left_d = left_q - 1'b1; st_d = ST_CAS; cnt_d = L_CSR;
        end else begin
          st_d = ST_IDLE; bon_d = 1'b0;
        end
      end
      ST_SRH: if (done && !sr_req) begin st_d = ST_SRX; cnt_d = L_RPS; end
      ST_SRX: if (done) begin
        sr_d = 1'b0;
        if (burst_sched) begin
          bon_d = 1'b1; left_d = L_BURST; st_d = ST_CAS; cnt_d = L_CSR;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      sr_q   <= 1'b0;
      bon_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      sr_q   <= sr_d;
      bon_q  <= bon_d;
    end
  end

  assign hold      = sr_q | bon_q;
  assign busy      = (st_q != ST_IDLE);
  assign ref_req   = (st_q == ST_IDLE) && (pending || sr_req);
  assign sr_active = (st_q == ST_SRH);
  assign ras_n     = !(st_q inside {ST_RAS, ST_SRH});
  assign cas_n     = !(st_q inside {ST_CAS, ST_RAS, ST_SRH});
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_MHZ     = 100,
  parameter int REF_NS      = 15625,
  parameter int MAX_BACKLOG = 8,
  parameter int CSR_CYC     = 1,
  parameter int RAS_CYC     = 5,
  parameter int RP_CYC      = 3,
  parameter int RASS_CYC    = 10000,
  parameter int RPS_CYC     = 11,
  parameter int BURST_ROWS  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic sr_req,
  input  logic burst_sched,
  output logic ref_req,
  output logic busy,
  output logic sr_active,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int INTERVAL = CLK_MHZ * REF_NS / 1000;

  logic tick, take, clear, hold, pending;

  refsched_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick)
  );

  refsched_backlog #(.MAX_BACKLOG(MAX_BACKLOG)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .clear(clear),
    .pending(pending)
  );

  refsched_fsm #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .RASS_CYC(RASS_CYC), .RPS_CYC(RPS_CYC), .BURST_ROWS(BURST_ROWS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pending(pending), .gnt(ref_gnt),
    .sr_req(sr_req), .burst_sched(burst_sched), .take(take), .clear(clear),
    .hold(hold), .ref_req(ref_req), .busy(busy), .sr_active(sr_active),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  assign we_n = 1'b1;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int RASS_CYC = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic ref_req,
  input logic busy,
  input logic sr_active,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  localparam int LW = $clog2(RASS_CYC + 2);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        low_cnt <= '0;
    else if (ras_n)                    low_cnt <= '0;
    else if (low_cnt != LW'(RASS_CYC + 1)) low_cnt <= low_cnt + 1'b1;
  end

  // R10
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n) we_n);

  // R3
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R3
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n));

  // R4
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !busy);

  // R6
  sr_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (!ras_n && !cas_n && busy));

  // R7
  sr_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(sr_active)) |-> (low_cnt >= LW'(RASS_CYC)));

  // R8
  sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (ras_n && cas_n && busy));
endmodule

bind refresh_sched refresh_sched_chk #(.RASS_CYC(RASS_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .busy(busy),
  .sr_active(sr_active), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CLK_MHZ = 100, REF_NS = 500, INTERVAL = 50;
  localparam int MAXB = 3, CSR = 1, RASC = 4, RP = 3, RASS = 20, RPS = 10, BURST = 5;

  logic clk, rst_n, ref_gnt, sr_req, burst_sched;
  logic ref_req, busy, sr_active, ras_n, cas_n, we_n;
  int tests, fails, falls, order_bad, we_bad;
  logic ras_prev;

  refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .REF_NS(REF_NS), .MAX_BACKLOG(MAXB), .CSR_CYC(CSR),
    .RAS_CYC(RASC), .RP_CYC(RP), .RASS_CYC(RASS), .RPS_CYC(RPS), .BURST_ROWS(BURST)
  ) u_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_req(sr_req),
    .burst_sched(burst_sched), .ref_req(ref_req), .busy(busy),
    .sr_active(sr_active), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  initial begin clk = 1'b0; forever #5 clk = ~clk; end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_prev && !ras_n) begin
        falls = falls + 1;
        if (cas_n) order_bad = order_bad + 1;
      end
      if (!we_n) we_bad = we_bad + 1;
    end
    ras_prev = ras_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_gnt = 1'b0; sr_req = 1'b0; burst_sched = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic grant_pulse();
    ref_gnt = 1'b1; step(1); ref_gnt = 1'b0;
  endtask

  // strobes packed as {busy, ras_n, cas_n}
  task automatic expect_strobes(input string req, input logic [2:0] exp);
    check({busy, ras_n, cas_n} == exp, req, int'({busy, ras_n, cas_n}), int'(exp));
  endtask

  task automatic t_reset_interval();
    do_reset();
    check(ras_n && cas_n && we_n && !ref_req && !busy && !sr_active, "R1",
          int'({ras_n, cas_n, we_n, ref_req, busy, sr_active}), 6'b111000);
    step(INTERVAL - 1);
    check(ref_req == 1'b0, "R2 one edge early", ref_req, 0);
    step(1);
    check(ref_req == 1'b1, "R2 at interval", ref_req, 1);
  endtask

  task automatic t_cbr_sequence();
    step(10);
    expect_strobes("R4 wait without grant", 3'b011);
    check(ref_req == 1'b1, "R4 request held", ref_req, 1);
    grant_pulse();
    expect_strobes("R3 cas first", 3'b110);
    for (int i = 0; i < RASC; i++) begin step(1); expect_strobes("R3 both low", 3'b100); end
    for (int i = 0; i < RP; i++) begin step(1); expect_strobes("R3 precharge", 3'b111); end
    step(1);
    expect_strobes("R3 released", 3'b011);
    check(ref_req == 1'b0, "R4 request cleared", ref_req, 0);
  endtask

  task automatic t_backlog();
    int base;
    do_reset();
    step(4 * INTERVAL + 5);
    base = falls;
    ref_gnt = 1'b1; step(30); ref_gnt = 1'b0;
    check(falls - base == MAXB, "R5 saturated backlog", falls - base, MAXB);
    check(ref_req == 1'b0 && !busy, "R5 drained", int'({ref_req, busy}), 0);
  endtask

  task automatic t_sr_distributed();
    int base;
    do_reset();
    sr_req = 1'b1;
    step(1);
    check(ref_req == 1'b1, "R6 request", ref_req, 1);
    grant_pulse();
    expect_strobes("R6 cas first", 3'b110);
    step(RASC + 40);
    check(sr_active && !ras_n && !cas_n, "R6 held", int'({sr_active, ras_n, cas_n}), 3'b100);
    base = falls;
    sr_req = 1'b0;
    step(1);
    check(!sr_active, "R8 exit flag", sr_active, 0);
    expect_strobes("R8 exit start", 3'b111);
    for (int i = 1; i < RPS; i++) begin step(1); expect_strobes("R8 exit hold", 3'b111); end
    step(1);
    expect_strobes("R8 exit done", 3'b011);
    step(20);
    check(falls == base, "R9 no burst", falls - base, 0);
    check(ref_req == 1'b0, "R9 timer restarted", ref_req, 0);
  endtask

  task automatic t_sr_short();
    int low;
    do_reset();
    sr_req = 1'b1;
    grant_pulse();
    step(2);
    sr_req = 1'b0;
    low = 1;
    for (int i = 0; i < 100; i++) begin
      if (ras_n) break;
      step(1);
      if (!ras_n) low++;
    end
    check(low >= RASS, "R7 minimum hold", low, RASS);
  endtask

  task automatic t_sr_burst();
    int base, guard;
    do_reset();
    burst_sched = 1'b1;
    sr_req = 1'b1;
    grant_pulse();
    step(30);
    base = falls;
    sr_req = 1'b0;
    step(1);
    guard = 0;
    while (busy && guard < 300) begin step(1); guard++; end
    check(falls - base == BURST, "R9 burst count", falls - base, BURST);
    check(!busy && !sr_active, "R9 burst ends", int'({busy, sr_active}), 0);
  endtask

  initial begin
    tests = 0; fails = 0; falls = 0; order_bad = 0; we_bad = 0; ras_prev = 1'b1;
    t_reset_interval();
    t_cbr_sequence();
    t_backlog();
    t_sr_distributed();
    t_sr_short();
    t_sr_burst();
    check(order_bad == 0, "R3 cas before ras", order_bad, 0);
    check(we_bad == 0, "R10 we high", we_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule